// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block produces the timing for a serial audio port. A source clock, either the module clock itself or an external clock pin, is divided by a programmable ratio to give the serial bit clock. A frame counter steps once per bit clock and produces frame sync pulses of programmable width. The frame length and the pulse width are both programmed as a count of bit clocks minus one, so a stereo 16-bit frame uses a period value of 31 and a width value of 15. Both output pins have selectable polarity.

There are two enables. The generator enable starts the bit clock. The frame sync enable then arms the frame counter, and frame sync cannot appear while the generator is stopped. Clearing either enable silences its output on the next cycle. In periodic mode, frame sync repeats on every frame. In load-triggered mode, each pulse on the load input schedules exactly one frame sync pulse, which begins on the next bit clock.

A one-cycle bit strobe goes with the bit clock rising edge, so a shifter downstream can act on it. The external pin runs through a synchronizer and a rising-edge detector. The pin must therefore toggle at less than half the module clock rate.

Top module: `bitclk_frame_gen`

## Requirements
- R1: With the internal source and divisor value D (D at least 1), `bit_strobe` pulses once every D+1 clock cycles. In each bit period the unpolarised bit clock is high for floor(D/2)+1 cycles, starting in the cycle after the strobe.
- R2: With `src_ext`=1, the divider advances once per rising edge of `ext_clk`, so the bit period is (D+1) pin periods. While the pin is static, no `bit_strobe` occurs.
- R3: In periodic mode (`periodic`=1), a frame lasts P+1 bit periods for period value P. Frame sync is active during the first W+1 bit periods of each frame, for width value W.
- R4: Frame sync becomes active in the bit period that starts at the first bit strobe after both enables are set. It is never active while `gen_en` is low, even with `fs_en` high.
- R5: In load-triggered mode (`periodic`=0), there is no frame sync without a load pulse. Each `fs_load` pulse gives one frame sync pulse of W+1 bit periods, starting at the next bit strobe.
- R6: One cycle after `gen_en` is sampled low, `bclk_out` sits at its idle level, `fs_out` is inactive and `bit_strobe` stays low.
- R7: One cycle after `fs_en` is sampled low, `fs_out` is inactive. The bit clock keeps running.
- R8: `bclk_inv`=1 inverts `bclk_out`, so its idle level becomes high. `fs_low`=1 makes `fs_out` active low.
- R9: After reset, `bit_strobe`=0, `bclk_out`=`bclk_inv` and `fs_out`=`fs_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, also the internal divider source |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External source clock pin (asynchronous) |
| gen_en | input | 1 | Bit clock generator enable |
| fs_en | input | 1 | Frame sync enable |
| src_ext | input | 1 | 1 selects `ext_clk` as the divider source |
| periodic | input | 1 | 1 gives periodic frame sync; 0 gives one pulse per load |
| fs_load | input | 1 | One-cycle request for a frame sync pulse in load-triggered mode |
| clk_div | input | DIV_W | Divisor value D; bit period is D+1 source ticks |
| frame_per | input | FRM_W | Frame length in bit clocks minus one |
| frame_wid | input | FRM_W | Frame sync pulse length in bit clocks minus one |
| bclk_inv | input | 1 | Bit clock output inversion |
| fs_low | input | 1 | Frame sync active-low select |
| bclk_out | output | 1 | Serial bit clock |
| fs_out | output | 1 | Frame sync |
| bit_strobe | output | 1 | One-cycle pulse ahead of each bit clock rising edge |

## Verification
The bench builds the block with DIV_W=8, FRM_W=8 and two synchronizer stages. The 8-bit frame fields are wide enough for the 32-bit stereo frame (period 31, width 15). The small divisors used (1, 3 and 6) keep each bit period to a few cycles, so two full stereo frames, the odd-divisor duty cycle and the frame wrap fit in a few hundred cycles. An external pin toggled every four cycles places the sixteen-cycle external bit period within reach, and stopping that pin shows the divider stalling.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_PIN      = 1'b1
  } clk_src_e;

  typedef enum logic {
    FS_ON_LOAD  = 1'b0,
    FS_PERIODIC = 1'b1
  } fs_mode_e;
endpackage

// File: rtl/bfg_pin_sync.sv
module bfg_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  // chain[STAGES-1] is the last synchronized stage, chain[STAGES] its history
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bfg_divider.sv
module bfg_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick,
  output logic             bclk_level
);
  logic             run;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half       = div >> 1;
  assign bit_tick   = run & src_tick & (cnt >= div);
  assign bclk_level = run & (cnt <= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!enable) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= 1'b1;
      if (bit_tick)            cnt <= '0;
      else if (run && src_tick) cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/bfg_framer.sv
module bfg_framer
  import bfg_pkg::*;
#(
  parameter int unsigned FRM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             fs_en,
  input  fs_mode_e         mode,
  input  logic             load,
  input  logic             bit_tick,
  input  logic [FRM_W-1:0] period,
  input  logic [FRM_W-1:0] width,
  output logic             fs_level
);
  logic             armed;
  logic             shot_act;
  logic             shot_pend;
  logic [FRM_W-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      shot_act  <= 1'b0;
      shot_pend <= 1'b0;
      fcnt      <= '0;
    end else if (!gen_en || !fs_en) begin
      armed     <= 1'b0;
      shot_act  <= 1'b0;
      shot_pend <= 1'b0;
      fcnt      <= '0;
    end else if (mode == FS_PERIODIC) begin
      shot_act  <= 1'b0;
      shot_pend <= 1'b0;
      if (bit_tick) begin
        if (!armed) begin
          armed <= 1'b1;
          fcnt  <= '0;
        end else if (fcnt >= period) begin
          fcnt <= '0;
        end else begin
          fcnt <= fcnt + FRM_W'(1);
        end
      end
    end else begin
      armed <= 1'b0;
      if (bit_tick) begin
        if (shot_act) begin
          shot_pend <= shot_pend | load;
          if (fcnt >= width) begin
            shot_act <= 1'b0;
            fcnt     <= '0;
          end else begin
            fcnt <= fcnt + FRM_W'(1);
          end
        end else if (shot_pend || load) begin
          shot_act  <= 1'b1;
          shot_pend <= 1'b0;
          fcnt      <= '0;
        end
      end else if (load) begin
        shot_pend <= 1'b1;
      end
    end
  end

  assign fs_level = (mode == FS_PERIODIC) ? (armed && (fcnt <= width)) : shot_act;
endmodule

// File: rtl/bitclk_frame_gen.sv
module bitclk_frame_gen
  import bfg_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned FRM_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             gen_en,
  input  logic             fs_en,
  input  logic             src_ext,
  input  logic             periodic,
  input  logic             fs_load,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [FRM_W-1:0] frame_per,
  input  logic [FRM_W-1:0] frame_wid,
  input  logic             bclk_inv,
  input  logic             fs_low,
  output logic             bclk_out,
  output logic             fs_out,
  output logic             bit_strobe
);
  localparam int unsigned STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  clk_src_e src_sel;
  fs_mode_e fs_mode;
  logic     pin_rise;
  logic     src_tick;
  logic     bit_tick;
  logic     bclk_level;
  logic     fs_level;

  assign src_sel = clk_src_e'(src_ext);
  assign fs_mode = fs_mode_e'(periodic);

  bfg_pin_sync #(.STAGES(STG)) u_pin_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (ext_clk),
    .rise_o (pin_rise)
  );

  assign src_tick = (src_sel == SRC_PIN) ? pin_rise : 1'b1;

  bfg_divider #(.DIV_W(DIV_W)) u_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (gen_en),
    .src_tick   (src_tick),
    .div        (clk_div),
    .bit_tick   (bit_tick),
    .bclk_level (bclk_level)
  );

  bfg_framer #(.FRM_W(FRM_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en),
    .fs_en    (fs_en),
    .mode     (fs_mode),
    .load     (fs_load),
    .bit_tick (bit_tick),
    .period   (frame_per),
    .width    (frame_wid),
    .fs_level (fs_level)
  );

  assign bclk_out   = bclk_level ^ bclk_inv;
  assign fs_out     = fs_level ^ fs_low;
  assign bit_strobe = bit_tick;
endmodule

// File: rtl/bfg_checker.sv
module bfg_checker (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic fs_en,
  input logic bclk_inv,
  input logic fs_low,
  input logic bclk_out,
  input logic fs_out,
  input logic bit_strobe
);
  logic bclk_act;
  logic fs_act;
  assign bclk_act = bclk_out ^ bclk_inv;
  assign fs_act   = fs_out ^ fs_low;

  assert_bclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (bclk_out == bclk_inv));

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !bit_strobe);

  assert_fs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_en |=> (fs_out == fs_low));

  assert_fs_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_act) |-> $past(bit_strobe));

  assert_bclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && gen_en) |=> bclk_act);
endmodule

bind bitclk_frame_gen bfg_checker u_bfg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .fs_en      (fs_en),
  .bclk_inv   (bclk_inv),
  .fs_low     (fs_low),
  .bclk_out   (bclk_out),
  .fs_out     (fs_out),
  .bit_strobe (bit_strobe)
);

// File: tb/bitclk_frame_gen_test.sv
`timescale 1ns/1ps
module bitclk_frame_gen_test;
  localparam int DW = 8;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic gen_en = 1'b0, fs_en = 1'b0, src_ext = 1'b0, periodic = 1'b1, fs_load = 1'b0;
  logic [DW-1:0] clk_div = 8'd1;
  logic [FW-1:0] frame_per = 8'd31, frame_wid = 8'd15;
  logic bclk_inv = 1'b0, fs_low = 1'b0;
  logic bclk_out, fs_out, bit_strobe;
  logic ext_on = 1'b0;

  int checks = 0;
  int fails = 0;
  logic seq [128];

  bitclk_frame_gen #(.DIV_W(DW), .FRM_W(FW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .gen_en(gen_en), .fs_en(fs_en),
    .src_ext(src_ext), .periodic(periodic), .fs_load(fs_load), .clk_div(clk_div),
    .frame_per(frame_per), .frame_wid(frame_wid), .bclk_inv(bclk_inv), .fs_low(fs_low),
    .bclk_out(bclk_out), .fs_out(fs_out), .bit_strobe(bit_strobe)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (ext_on) ext_clk = ~ext_clk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_strobe(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (bit_strobe) begin
        ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic collect(input int n);
    bit ok;
    for (int i = 0; i < n; i++) begin
      wait_strobe(ok);
      @(negedge clk);
      seq[i] = ok ? (fs_out ^ fs_low) : 1'bx;
    end
  endtask

  task automatic idle();
    gen_en = 1'b0; fs_en = 1'b0; fs_load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bit_strobe == 1'b0, "R9 strobe after reset", int'(bit_strobe), 0);
    check(bclk_out == bclk_inv, "R9 bclk idle after reset", int'(bclk_out), int'(bclk_inv));
    check(fs_out == fs_low, "R9 fs idle after reset", int'(fs_out), int'(fs_low));
  endtask

  task automatic t_divider(input int d);
    bit ok;
    int hi = 0;
    int early = 0;
    idle();
    src_ext = 1'b0; clk_div = DW'(d); gen_en = 1'b1;
    wait_strobe(ok);
    for (int k = 1; k <= d + 1; k++) begin
      @(negedge clk);
      if (bclk_out ^ bclk_inv) hi++;
      if (bit_strobe && k != d + 1) early++;
      if (k == d + 1 && !bit_strobe) early++;
    end
    check(ok && early == 0, $sformatf("R1 strobe period div=%0d", d), early, 0);
    check(hi == d / 2 + 1, $sformatf("R1 high cycles div=%0d", d), hi, d / 2 + 1);
  endtask

  task automatic t_external();
    bit ok;
    int gap;
    int seen = 0;
    idle();
    src_ext = 1'b1; clk_div = 8'd1; ext_on = 1'b1; gen_en = 1'b1;
    wait_strobe(ok);
    for (int r = 0; r < 2; r++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!bit_strobe && gap < 100);
      check(gap == 16, "R2 external bit period", gap, 16);
    end
    ext_on = 1'b0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (bit_strobe) seen++;
    end
    check(seen == 0, "R2 static pin gives no strobe", seen, 0);
    src_ext = 1'b0;
  endtask

  task automatic t_periodic(input int per, input int wid, input int d, input int n);
    int bad = 0;
    idle();
    periodic = 1'b1; clk_div = DW'(d); frame_per = FW'(per); frame_wid = FW'(wid);
    gen_en = 1'b1; fs_en = 1'b1;
    collect(n);
    for (int i = 0; i < n; i++)
      if (seq[i] !== (((i % (per + 1)) <= wid) ? 1'b1 : 1'b0)) bad++;
    check(bad == 0, $sformatf("R3 frame pattern per=%0d wid=%0d", per, wid), bad, 0);
  endtask

  task automatic t_first_pulse();
    int act = 0;
    bit ok;
    idle();
    periodic = 1'b1; clk_div = 8'd3; frame_per = 8'd7; frame_wid = 8'd1;
    fs_en = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (fs_out ^ fs_low) act++;
    end
    check(act == 0, "R4 no frame sync while generator stopped", act, 0);
    gen_en = 1'b1;
    collect(1);
    check(seq[0] === 1'b1, "R4 first bit after joint enable", int'(seq[0]), 1);
    idle();
    gen_en = 1'b1;
    repeat (9) @(negedge clk);
    fs_en = 1'b1;
    wait_strobe(ok);
    check(ok && (fs_out ^ fs_low) == 1'b0, "R4 inactive until bit strobe", int'(fs_out ^ fs_low), 0);
    @(negedge clk);
    check((fs_out ^ fs_low) == 1'b1, "R4 active on first bit after fs_en", int'(fs_out ^ fs_low), 1);
  endtask

  task automatic t_oneshot();
    bit ok;
    int bad = 0;
    int act = 0;
    idle();
    periodic = 1'b0; clk_div = 8'd3; frame_per = 8'd31; frame_wid = 8'd3;
    gen_en = 1'b1; fs_en = 1'b1;
    collect(20);
    for (int i = 0; i < 20; i++) if (seq[i] !== 1'b0) act++;
    check(act == 0, "R5 no pulse without load", act, 0);
    wait_strobe(ok);
    @(negedge clk);
    fs_load = 1'b1;
    @(negedge clk);
    fs_load = 1'b0;
    collect(10);
    for (int i = 0; i < 10; i++)
      if (seq[i] !== ((i <= 3) ? 1'b1 : 1'b0)) bad++;
    check(bad == 0, "R5 single pulse of width+1 bits", bad, 0);
    idle();
    periodic = 1'b1;
  endtask

  task automatic t_stop();
    bit ok;
    int seen = 0;
    idle();
    periodic = 1'b1; clk_div = 8'd1; frame_per = 8'd7; frame_wid = 8'd3;
    gen_en = 1'b1; fs_en = 1'b1;
    wait_strobe(ok);
    @(negedge clk);
    gen_en = 1'b0;
    @(negedge clk);
    check((bclk_out ^ bclk_inv) == 1'b0, "R6 bclk idle after stop", int'(bclk_out ^ bclk_inv), 0);
    check((fs_out ^ fs_low) == 1'b0, "R6 fs inactive after stop", int'(fs_out ^ fs_low), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bit_strobe) seen++;
    end
    check(seen == 0, "R6 no strobe while stopped", seen, 0);
  endtask

  task automatic t_fs_off();
    bit ok;
    idle();
    periodic = 1'b1; clk_div = 8'd1; frame_per = 8'd7; frame_wid = 8'd3;
    gen_en = 1'b1; fs_en = 1'b1;
    wait_strobe(ok);
    @(negedge clk);
    fs_en = 1'b0;
    @(negedge clk);
    check((fs_out ^ fs_low) == 1'b0, "R7 fs inactive after fs_en low", int'(fs_out ^ fs_low), 0);
    wait_strobe(ok);
    check(ok, "R7 bit clock keeps running", int'(ok), 1);
  endtask

  task automatic t_polarity();
    bit ok;
    idle();
    bclk_inv = 1'b1; fs_low = 1'b1;
    repeat (2) @(negedge clk);
    check(bclk_out == 1'b1, "R8 inverted bclk idles high", int'(bclk_out), 1);
    check(fs_out == 1'b1, "R8 active-low fs idles high", int'(fs_out), 1);
    periodic = 1'b1; clk_div = 8'd3; frame_per = 8'd7; frame_wid = 8'd3;
    gen_en = 1'b1; fs_en = 1'b1;
    wait_strobe(ok);
    @(negedge clk);
    check(bclk_out == 1'b0, "R8 inverted bclk low in active phase", int'(bclk_out), 0);
    check(fs_out == 1'b0, "R8 fs driven low when active", int'(fs_out), 0);
    idle();
    bclk_inv = 1'b0; fs_low = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divider(3);
    t_divider(6);
    t_divider(1);
    t_external();
    t_periodic(31, 15, 1, 64);
    t_periodic(7, 2, 2, 24);
    t_first_pulse();
    t_oneshot();
    t_stop();
    t_fs_off();
    t_polarity();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all R): actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule